// File: doc/BRIEF.md
# Correlating BPSK Bit Demodulator

This block turns a stream of sampled BPSK waveform codes into data bits. Every qualified clock brings one ADC sample and one sample of a local carrier reference that is assumed to be already phase-aligned with the received carrier. Both arrive as offset-binary codes. The block forms the 180-degree inverse of the reference and converts all three codes to sign and magnitude. It multiplies the ADC magnitude by each reference magnitude and adds the signed products into two correlators, one for each reference phase.

A free-running bit timer splits time into fixed bit periods. At the end of each period the two correlators are compared and one hard decision bit is issued with a one-cycle valid pulse. Both correlators then restart. Because a bit can only be decided after its whole period has been integrated, the output stream trails the input by one bit period. Carrier recovery, the converter and any error-rate measurement belong to other blocks.

Top module: `bpsk_corr_demod`

## Requirements
- R1: Codes are offset binary of SAMP_W bits. Z = 2^(SAMP_W-1)-1 (0x1FFF for 14 bits) is zero, and full scale F = 2*Z (0x3FFE). A code c >= Z converts to magnitude c-Z with sign 0, and c < Z converts to magnitude Z-c with sign 1. A code above F is saturated to F before use.
- R2: The inverted reference code is F minus the (saturated) reference code.
- R3: Each product takes the ADC magnitude times a reference magnitude, with sign equal to the XOR of the operand signs. The reference-lane product goes into correlator 1 and the inverted-lane product into correlator 2, both in two's complement.
- R4: The bit timer wraps every BIT_CLKS clocks. The first wrap falls on the BIT_CLKS-th rising edge after reset is released, and bit_valid is high for exactly one cycle after each wrap edge and low otherwise.
- R5: At a wrap, bit_out becomes 1 when correlator 1 is strictly greater than correlator 2 and 0 otherwise, so a tie gives 0.
- R6: At a wrap both correlators restart from zero. If a product is ready in that same cycle it is loaded, so it counts toward the next bit.
- R7: A sample taken at rising edge k reaches the correlators at edge k+2. Bit j (j = 1, 2, ...) therefore covers the samples taken at edges k with (j-1)*BIT_CLKS <= k+2 <= j*BIT_CLKS-1.
- R8: The correlators are wide enough (2*(SAMP_W-1)+1+clog2(BIT_CLKS) bits, 44 by default) that a full period of full-scale products never overflows.
- R9: Synchronous active-low reset clears the timer, both correlators, bit_out and bit_valid.
- R10: A sample whose strobe is low contributes nothing to either correlator.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Qualifies adc_code and ref_code in this cycle |
| adc_code | input | SAMP_W | Received waveform sample, offset binary |
| ref_code | input | SAMP_W | Local carrier reference sample, offset binary |
| bit_out | output | 1 | Decided bit of the last completed period |
| bit_valid | output | 1 | One-cycle pulse marking a new bit_out |

## Verification
The bench runs several kinds of bit period. In-phase and anti-phase periods separate the two decision values. Periods at full scale and with over-range codes exercise the conversion and saturation, and also expose a sign or offset error. Periods with the strobe low, or with a zero ADC code, produce an exact tie and so confirm that a tie decides 0. A period carrying only its first sample, next to one carrying only its last sample, pins the window boundary and the two-cycle latency to the exact edge. Pseudo-random noise periods compare the correlators against an integer model.

// File: rtl/bpsk_corr_pkg.sv
// Package: shared constants, lane naming and width helpers for the
// correlating BPSK demodulator. Assumes offset-binary samples.
package bpsk_corr_pkg;

    localparam int unsigned DEF_SAMP_W   = 14;
    localparam int unsigned DEF_BIT_CLKS = 100000;
    localparam int unsigned N_LANES      = 2;

    // Lane index: reference phase and inverted (180-degree) phase.
    typedef enum logic {
        LANE_REF = 1'b0,
        LANE_INV = 1'b1
    } lane_e;

    // Correlator width: signed product plus growth over one period.
    function automatic int unsigned corr_width(int unsigned samp_w,
                                               int unsigned bit_clks);
        return 2 * (samp_w - 1) + 1 + $clog2(bit_clks);
    endfunction

endpackage

// File: rtl/bpsk_smp_latch.sv
// Module: input latch stage. Registers the strobe, the ADC code, the
// reference code and its inverse. Codes above full scale are saturated
// so that every later stage sees a code in 0..F.
// Assumes: offset-binary codes, F = 2^SAMP_W - 2.
module bpsk_smp_latch #(
    parameter int unsigned SAMP_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_i,
    input  logic [SAMP_W-1:0] adc_i,
    input  logic [SAMP_W-1:0] ref_i,
    output logic              stb_o,
    output logic [SAMP_W-1:0] adc_o,
    output logic [SAMP_W-1:0] ref_o,
    output logic [SAMP_W-1:0] inv_o
);
    localparam logic [SAMP_W-1:0] FULL = SAMP_W'((2 ** SAMP_W) - 2);
    localparam logic [SAMP_W-1:0] MID  = SAMP_W'((2 ** (SAMP_W - 1)) - 1);

    logic [SAMP_W-1:0] adc_sat;
    logic [SAMP_W-1:0] ref_sat;

    // Clamp the single over-range code down to full scale.
    always_comb begin
        adc_sat = (adc_i > FULL) ? FULL : adc_i;
        ref_sat = (ref_i > FULL) ? FULL : ref_i;
    end

    // Capture the qualified sample set and form the inverted reference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_o <= 1'b0;
            adc_o <= MID;
            ref_o <= MID;
            inv_o <= MID;
        end else begin
            stb_o <= stb_i;
            adc_o <= adc_sat;
            ref_o <= ref_sat;
            inv_o <= FULL - ref_sat;
        end
    end

    // R2: the reference and its inverse always sum to full scale.
    p_inv_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_o + inv_o) == FULL)
        else $error("inverse reference does not mirror");

    // R1: latched codes never exceed full scale.
    p_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_o <= FULL) && (ref_o <= FULL))
        else $error("latched code out of range");

endmodule

// File: rtl/bpsk_sm_conv.sv
// Module: offset-binary to sign-magnitude converter (combinational).
// Codes at or above mid-scale are positive, codes below it are negative.
// Assumes: input code is within 0..F, so the magnitude fits SAMP_W-1 bits.
module bpsk_sm_conv #(
    parameter int unsigned SAMP_W = 14,
    localparam int unsigned MAG_W = SAMP_W - 1
) (
    input  logic [SAMP_W-1:0] code_i,
    output logic              sgn_o,
    output logic [MAG_W-1:0]  mag_o
);
    localparam logic [SAMP_W-1:0] MID = SAMP_W'((2 ** (SAMP_W - 1)) - 1);

    logic [SAMP_W-1:0] diff;

    // Split the code into a sign and a distance from mid-scale.
    always_comb begin
        if (code_i >= MID) begin
            sgn_o = 1'b0;
            diff  = code_i - MID;
        end else begin
            sgn_o = 1'b1;
            diff  = MID - code_i;
        end
        mag_o = diff[MAG_W-1:0];
    end

endmodule

// File: rtl/bpsk_corr_mult.sv
// Module: multiply stage. Converts the latched codes to sign-magnitude,
// multiplies the ADC magnitude by each reference magnitude and registers
// the two products in two's complement, one per lane.
// Assumes: codes already saturated to 0..F by the latch stage.
module bpsk_corr_mult
    import bpsk_corr_pkg::*;
#(
    parameter int unsigned SAMP_W = 14,
    localparam int unsigned MAG_W  = SAMP_W - 1,
    localparam int unsigned PROD_W = 2 * MAG_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             vld_i,
    input  logic [SAMP_W-1:0]                adc_i,
    input  logic [SAMP_W-1:0]                ref_i,
    input  logic [SAMP_W-1:0]                inv_i,
    output logic                             vld_o,
    output logic [N_LANES-1:0][PROD_W-1:0]   prod_o
);
    localparam int unsigned N_CODES = N_LANES + 1;

    logic [N_CODES-1:0][SAMP_W-1:0] codes;
    logic [N_CODES-1:0]             sgn;
    logic [N_CODES-1:0][MAG_W-1:0]  mag;

    // Slot 0 is the ADC, slots 1.. are the reference lanes.
    always_comb begin
        codes[0]                       = adc_i;
        codes[int'(LANE_REF) + 1]      = ref_i;
        codes[int'(LANE_INV) + 1]      = inv_i;
    end

    for (genvar c = 0; c < N_CODES; c++) begin : g_conv
        bpsk_sm_conv #(.SAMP_W(SAMP_W)) u_conv (
            .code_i (codes[c]),
            .sgn_o  (sgn[c]),
            .mag_o  (mag[c])
        );
    end

    // Carry the strobe alongside the products.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    for (genvar l = 0; l < N_LANES; l++) begin : g_lane
        logic [2*MAG_W-1:0] mag_prod;
        logic               prod_sgn;
        logic [PROD_W-1:0]  prod_tc;

        // Magnitude product, sign from the XOR of operand signs, then negate.
        always_comb begin
            mag_prod = mag[0] * mag[l + 1];
            prod_sgn = sgn[0] ^ sgn[l + 1];
            prod_tc  = prod_sgn ? (PROD_W'(0) - {1'b0, mag_prod})
                                : {1'b0, mag_prod};
        end

        // Register the signed product of this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) prod_o[l] <= '0;
            else        prod_o[l] <= prod_tc;
        end
    end

    // R3: the two lanes see opposite references, so products are negatives.
    p_lanes_opposite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (prod_o[int'(LANE_REF)] == (PROD_W'(0) - prod_o[int'(LANE_INV)])))
        else $error("lane products not mirrored");

endmodule

// File: rtl/bpsk_bit_timer.sv
// Module: bit-period timer. Free-running counter that flags the last
// clock of each bit period and then returns to zero.
// Assumes: BIT_CLKS >= 2.
module bpsk_bit_timer #(
    parameter int unsigned BIT_CLKS = 100000,
    localparam int unsigned CNT_W   = $clog2(BIT_CLKS)
) (
    input  logic clk,
    input  logic rst_n,
    output logic wrap_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_CLKS - 1);

    logic [CNT_W-1:0] cnt_q;

    // Wrap flag marks the final clock of the period.
    always_comb wrap_o = (cnt_q == LAST);

    // Advance the counter, rolling over at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wrap_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // R4: the counter never leaves its range.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST)
        else $error("bit counter out of range");

    // R4: a wrap is always followed by a fresh period starting at zero.
    p_wrap_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cnt_q == '0) && !wrap_o)
        else $error("bit counter did not restart");

    // R9: reset leaves the counter at zero.
    p_reset_cnt_r9: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0))
        else $error("counter not cleared by reset");

endmodule

// File: rtl/bpsk_corr_acc.sv
// Module: twin correlators and decision. Sums reference-lane and
// inverted-lane products over one bit period, compares them at the wrap,
// issues the bit with a one-cycle valid and restarts both sums.
// Assumes: ACC_W is large enough for one full period of products.
module bpsk_corr_acc
    import bpsk_corr_pkg::*;
#(
    parameter int unsigned PROD_W = 27,
    parameter int unsigned ACC_W  = 44
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wrap_i,
    input  logic                           vld_i,
    input  logic [N_LANES-1:0][PROD_W-1:0] prod_i,
    output logic                           bit_o,
    output logic                           valid_o
);
    localparam int unsigned EXT_W = ACC_W - PROD_W;

    logic [N_LANES-1:0][ACC_W-1:0] acc_q;
    logic [N_LANES-1:0][ACC_W-1:0] add_term;

    for (genvar l = 0; l < N_LANES; l++) begin : g_acc
        // Sign-extend the product, or zero when no sample is present.
        always_comb begin
            add_term[l] = vld_i ? {{EXT_W{prod_i[l][PROD_W-1]}}, prod_i[l]}
                                : '0;
        end

        // Integrate, or restart with this cycle's product at the wrap.
        always_ff @(posedge clk) begin
            if (!rst_n)      acc_q[l] <= '0;
            else if (wrap_i) acc_q[l] <= add_term[l];
            else             acc_q[l] <= acc_q[l] + add_term[l];
        end
    end

    // Decide the bit from the finished sums and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= wrap_i;
            if (wrap_i) begin
                bit_o <= ($signed(acc_q[int'(LANE_REF)]) >
                          $signed(acc_q[int'(LANE_INV)]));
            end
        end
    end

    // R3: with mirrored lanes the two sums stay exact negatives.
    p_acc_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q[int'(LANE_REF)] == (ACC_W'(0) - acc_q[int'(LANE_INV)]))
        else $error("correlators diverged");

    // R6 / R10: a wrap without a sample leaves both sums at zero.
    p_restart_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !vld_i) |=> (acc_q[0] == '0) && (acc_q[1] == '0))
        else $error("correlators not cleared at wrap");

    // R4: valid follows the wrap by one cycle and only then.
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> valid_o)
        else $error("missing valid after wrap");
    p_valid_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> !valid_o)
        else $error("valid without wrap");

    // R8: adding a like-signed term never flips the sign of the sum.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_i && vld_i &&
         (acc_q[0][ACC_W-1] == add_term[0][ACC_W-1]))
        |=> (acc_q[0][ACC_W-1] == $past(acc_q[0][ACC_W-1])))
        else $error("correlator overflow");

    // R9: reset clears the output flags.
    p_reset_out_r9: assert property (@(posedge clk)
        !rst_n |=> !valid_o && !bit_o)
        else $error("outputs not cleared by reset");

endmodule

// File: rtl/bpsk_corr_demod.sv
// Module: top of the correlating BPSK bit demodulator. Latch stage,
// sign-magnitude multiply stage, bit timer and twin correlators.
// Assumes: reference phase-aligned with the received carrier; a sample
// at edge k reaches the correlators at edge k+2.
module bpsk_corr_demod
    import bpsk_corr_pkg::*;
#(
    parameter int unsigned SAMP_W   = DEF_SAMP_W,
    parameter int unsigned BIT_CLKS = DEF_BIT_CLKS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic [SAMP_W-1:0] adc_code,
    input  logic [SAMP_W-1:0] ref_code,
    output logic              bit_out,
    output logic              bit_valid
);
    localparam int unsigned MAG_W  = SAMP_W - 1;
    localparam int unsigned PROD_W = 2 * MAG_W + 1;
    localparam int unsigned ACC_W  = corr_width(SAMP_W, BIT_CLKS);

    logic                           lat_stb;
    logic [SAMP_W-1:0]              lat_adc;
    logic [SAMP_W-1:0]              lat_ref;
    logic [SAMP_W-1:0]              lat_inv;
    logic                           prod_vld;
    logic [N_LANES-1:0][PROD_W-1:0] prod;
    logic                           wrap;

    bpsk_smp_latch #(.SAMP_W(SAMP_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .stb_i (smp_stb),
        .adc_i (adc_code),
        .ref_i (ref_code),
        .stb_o (lat_stb),
        .adc_o (lat_adc),
        .ref_o (lat_ref),
        .inv_o (lat_inv)
    );

    bpsk_corr_mult #(.SAMP_W(SAMP_W)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (lat_stb),
        .adc_i  (lat_adc),
        .ref_i  (lat_ref),
        .inv_i  (lat_inv),
        .vld_o  (prod_vld),
        .prod_o (prod)
    );

    bpsk_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap_o (wrap)
    );

    bpsk_corr_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap_i  (wrap),
        .vld_i   (prod_vld),
        .prod_i  (prod),
        .bit_o   (bit_out),
        .valid_o (bit_valid)
    );

endmodule

// File: tb/tb_bpsk_corr_demod.sv
// Scoreboard bench: the driver applies one pattern per bit period, models
// the correlators in integers and queues the expected bit; the monitor
// pops and compares on every bit_valid.
module tb_bpsk_corr_demod;
    localparam int SW    = 14;
    localparam int N     = 16;
    localparam int NWIN  = 18;
    localparam int ZERO  = 8191;
    localparam int FULL  = 16382;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_stb = 1'b0;
    logic [SW-1:0] adc_code = SW'(ZERO);
    logic [SW-1:0] ref_code = SW'(ZERO);
    logic          bit_out;
    logic          bit_valid;

    int     total = 0;
    int     bad = 0;
    int     edge_no = 0;
    bit     done = 1'b0;
    bit     exp_q[$];
    string  tag_q[$];
    longint acc1[NWIN];
    longint acc2[NWIN];
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    bpsk_corr_demod #(.SAMP_W(SW), .BIT_CLKS(N)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_stb   (smp_stb),
        .adc_code  (adc_code),
        .ref_code  (ref_code),
        .bit_out   (bit_out),
        .bit_valid (bit_valid)
    );

    // Index of rising edges since reset release.
    always @(posedge clk) if (rst_n) edge_no <= edge_no + 1;

    function automatic int sat(int c);
        return (c > FULL) ? FULL : c;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rnd();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return int'(lf[13:0]);
    endfunction

    function automatic string win_tag(int p);
        case (p)
            0: return "R5 in-phase";
            1: return "R2 anti-phase";
            2: return "R10 strobe-low tie";
            3: return "R1 full-scale saturation";
            4: return "R10 gated anti-phase";
            5: return "R5 zero-adc tie";
            6: return "R7 last-sample boundary";
            7: return "R6 first-sample boundary";
            default: return "R3 noise";
        endcase
    endfunction

    // Driver: one sample per edge, integer model, expected bit queued.
    initial begin
        for (int w = 0; w < NWIN; w++) begin
            acc1[w] = 0;
            acc2[w] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset bit_out", int'(bit_out), 0);
        check("R9 reset bit_valid", int'(bit_valid), 0);
        rst_n = 1'b1;
        for (int k = 1; k <= NWIN * N - 3; k++) begin
            int w, o, p, r, a, va, vr, vi;
            bit s;
            w = (k + 2) / N;
            o = (k + 2) % N;
            p = w % 9;
            r = rnd();
            a = ZERO;
            s = 1'b1;
            case (p)
                0: a = r;
                1: begin r = sat(r); a = FULL - r; end
                2: begin a = r; s = 1'b0; end
                3: begin r = (o % 2 == 0) ? 16383 : 0; a = r; end
                4: begin
                    if (o % 2 == 0) a = r;
                    else begin r = sat(r); a = FULL - r; s = 1'b0; end
                end
                5: a = ZERO;
                6: begin a = r; s = (o == N - 1); end
                7: begin r = sat(r); a = FULL - r; s = (o == 0); end
                default: a = rnd();
            endcase
            adc_code = SW'(a);
            ref_code = SW'(r);
            smp_stb  = s;
            if (s) begin
                va = sat(a) - ZERO;
                vr = sat(r) - ZERO;
                vi = (FULL - sat(r)) - ZERO;
                acc1[w] += longint'(va) * longint'(vr);
                acc2[w] += longint'(va) * longint'(vi);
            end
            if (o == N - 1) begin
                exp_q.push_back(acc1[w] > acc2[w]);
                tag_q.push_back(win_tag(p));
            end
            @(negedge clk);
        end
        smp_stb = 1'b0;
        while (edge_no < NWIN * N + 2) @(negedge clk);
        done = 1'b1;
        check("R4 all bits delivered", exp_q.size(), 0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 reset clears bit_out", int'(bit_out), 0);
        check("R9 reset clears bit_valid", int'(bit_valid), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Monitor: valid only on period edges, compare the decided bit.
    always @(negedge clk) begin
        if (rst_n && !done && edge_no > 0 && edge_no <= NWIN * N) begin
            if (bit_valid) begin
                check("R4 valid on period edge", edge_no % N, 0);
                if (exp_q.size() == 0) begin
                    check("R4 unexpected bit", 1, 0);
                end else begin
                    bit    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, int'(bit_out), int'(e));
                end
            end else if (edge_no % N == 0) begin
                check("R4 valid missing at wrap", 0, 1);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule